// File: doc/BRIEF.md
# Interrupt Command IPI Decoder

This block turns software writes to a 64-bit interrupt command register into interprocessor interrupt requests for a downstream destination resolver. Register writes arrive as an index plus 64 bits of data. The index selects the low command word, the high command word or a self-interrupt register. The block decodes the command fields and sorts each command into one of three kinds: a normal send, an arbitration-ID resynchronisation (an INIT level-deassert), or a startup request. The resolver then works out which processors are targeted and acts on the kind.

A mode input selects between two addressing styles. In the compact style, the command is written as two 32-bit halves. The high half only stores an 8-bit destination, and writing the low half fires the command. In the extended style, one write to the low index carries the full 32-bit destination in bits [63:32]. A separate high-half write is refused, and a self-interrupt register becomes available.

The resolver sees each request as a single-cycle valid pulse. Its ready input applies back-pressure: while ready is low, one command waits in a slot, and a further command write is refused. Refused writes and writes to unknown indices produce a one-cycle error pulse. An unknown index also sets a sticky illegal-address flag.

Top module: `ipi_cmd_decoder`

## Requirements
- R1: A write to the low command index (0x30) decodes vector = data[7:0], delivery mode = data[10:8], destination mode = data[11], level = data[14], trigger = data[15] and shorthand = data[19:18]. Every other bit of the low word has no effect on the request.
- R2: In compact mode (mode input 0), the destination is the high word's bits [31:24], zero-extended to 32 bits. A write to the high index (0x31) stores that word and sends nothing.
- R3: In extended mode (mode input 1), a low-index write loads the high word from data[63:32], and that full value is the destination. A high-index write is refused and leaves the stored high word unchanged.
- R4: Delivery mode 3'b101 with level 0 and trigger 1 gives request kind 1 (arbitration resync). Every other code except 3'b110 gives kind 0 (send).
- R5: Delivery mode 3'b110 gives request kind 2 (startup), and the vector is carried as the startup vector.
- R6: In extended mode, a write to the self index (0x3F) sends kind 0 with vector data[7:0], shorthand 2'b01, delivery mode 0, destination mode 0, trigger 0 and destination 0. In compact mode the same write is refused.
- R7: A write to any other index pulses the error output and sets the illegal-address flag, which then stays set until reset. No request is made.
- R8: A refused write raises the error output for exactly the cycle after the write edge, makes no request and changes no stored state.
- R9: A command accepted while ready is high and the slot is empty appears as a one-cycle valid pulse in the cycle after the write edge. The fields stay held after the pulse.
- R10: A command accepted while ready is low waits in a one-entry slot and is issued at the first edge where ready is high. A command write that arrives while the slot is full is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode_i | input | 1 | 1 selects extended addressing |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W | Register index |
| wr_data_i | input | 64 | Write data |
| wr_err_o | output | 1 | One-cycle error pulse for a refused or illegal write |
| esr_illegal_o | output | 1 | Sticky illegal-address flag |
| req_ready_i | input | 1 | Resolver can take a request |
| req_valid_o | output | 1 | One-cycle request pulse |
| req_kind_o | output | 2 | 0 send, 1 arbitration resync, 2 startup |
| req_vector_o | output | 8 | Vector |
| req_dlv_o | output | 3 | Delivery mode |
| req_dest_mode_o | output | 1 | Destination mode |
| req_trigger_o | output | 1 | Trigger |
| req_shorthand_o | output | 2 | Destination shorthand |
| req_dest_o | output | 32 | Destination |

## Verification
A wrong stored high word shows up only at the next low-index write, as a bad destination in that request. The bench therefore checks every refused high write through a later send. A misplaced decode bit or a misclassified kind shows up in the very pulse that follows the write edge, so a sweep over every combination of delivery mode, level, trigger, shorthand and destination mode exposes it at once. A slot that wrongly stays busy or wrongly clears shows up as a missing, duplicated or early pulse, or as a wrong error pulse on the next command write.

// File: rtl/ipi_cmd_pkg.sv
`timescale 1ns/1ps
package ipi_cmd_pkg;
  localparam int DEST_W = 32;
  localparam int VEC_W  = 8;

  typedef enum logic [1:0] {
    KIND_SEND     = 2'd0,
    KIND_ARB_SYNC = 2'd1,
    KIND_STARTUP  = 2'd2
  } ipi_kind_e;

  localparam logic [2:0] DLV_FIXED   = 3'b000;
  localparam logic [2:0] DLV_INIT    = 3'b101;
  localparam logic [2:0] DLV_STARTUP = 3'b110;
  localparam logic [1:0] SH_SELF     = 2'b01;

  typedef struct packed {
    ipi_kind_e           kind;
    logic [VEC_W-1:0]    vector;
    logic [2:0]          dlv;
    logic                dest_mode;
    logic                trigger;
    logic [1:0]          shorthand;
    logic [DEST_W-1:0]   dest;
  } ipi_req_t;

  // Sort a command into the kind the resolver acts on.
  function automatic ipi_kind_e f_kind(input logic [2:0] dlv, input logic lvl,
                                       input logic trg);
    if (dlv == DLV_STARTUP)                  return KIND_STARTUP;
    if (dlv == DLV_INIT && !lvl && trg)      return KIND_ARB_SYNC;
    return KIND_SEND;
  endfunction

  // Destination as seen in each addressing style.
  function automatic logic [DEST_W-1:0] f_dest(input logic ext,
                                               input logic [31:0] hi);
    if (ext) return hi;
    return {{(DEST_W-8){1'b0}}, hi[31:24]};
  endfunction

  function automatic ipi_req_t f_decode(input logic [31:0] lo,
                                        input logic [DEST_W-1:0] dest);
    ipi_req_t r;
    r.kind      = f_kind(lo[10:8], lo[14], lo[15]);
    r.vector    = lo[7:0];
    r.dlv       = lo[10:8];
    r.dest_mode = lo[11];
    r.trigger   = lo[15];
    r.shorthand = lo[19:18];
    r.dest      = dest;
    return r;
  endfunction

  function automatic ipi_req_t f_self(input logic [VEC_W-1:0] vec);
    ipi_req_t r;
    r.kind      = KIND_SEND;
    r.vector    = vec;
    r.dlv       = DLV_FIXED;
    r.dest_mode = 1'b0;
    r.trigger   = 1'b0;
    r.shorthand = SH_SELF;
    r.dest      = '0;
    return r;
  endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
`timescale 1ns/1ps
module ipi_cmd_regs
  import ipi_cmd_pkg::*;
#(
  parameter int             IDX_W      = 8,
  parameter logic [IDX_W-1:0] IDX_CMD_LO = 8'h30,
  parameter logic [IDX_W-1:0] IDX_CMD_HI = 8'h31,
  parameter logic [IDX_W-1:0] IDX_SELF   = 8'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [63:0]      wr_data_i,
  input  logic             slot_busy_i,
  output logic             cmd_fire_o,
  output ipi_req_t         cmd_o,
  output logic             wr_reject_o,
  output logic             wr_illegal_o
);
  logic [31:0] hi_q;
  logic [31:0] hi_next;
  logic        is_lo, is_hi, is_self, is_known, is_cmd;

  always_comb begin
    is_lo    = (wr_idx_i == IDX_CMD_LO);
    is_hi    = (wr_idx_i == IDX_CMD_HI);
    is_self  = (wr_idx_i == IDX_SELF);
    is_known = is_lo | is_hi | is_self;
    is_cmd   = is_lo | is_self;
  end

  always_comb begin
    wr_reject_o  = wr_en_i && ((is_hi && ext_mode_i) ||
                               (is_self && !ext_mode_i) ||
                               (is_cmd && slot_busy_i));
    wr_illegal_o = wr_en_i && !is_known;
    cmd_fire_o   = wr_en_i && is_cmd && !wr_reject_o;
  end

  always_comb begin
    hi_next = ext_mode_i ? wr_data_i[63:32] : hi_q;
    if (is_self) cmd_o = f_self(wr_data_i[VEC_W-1:0]);
    else         cmd_o = f_decode(wr_data_i[31:0], f_dest(ext_mode_i, hi_next));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_en_i && !wr_reject_o) begin
      if (is_lo && ext_mode_i) hi_q <= wr_data_i[63:32];
      if (is_hi)               hi_q <= wr_data_i[31:0];
    end
  end
endmodule

// File: rtl/ipi_cmd_issue.sv
`timescale 1ns/1ps
module ipi_cmd_issue
  import ipi_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_fire_i,
  input  ipi_req_t cmd_i,
  input  logic     req_ready_i,
  output logic     req_valid_o,
  output ipi_req_t req_o,
  output logic     slot_busy_o
);
  logic     pend_q;
  ipi_req_t pend_req_q;
  logic     valid_q;
  ipi_req_t out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_req_q <= '0;
      valid_q    <= 1'b0;
      out_q      <= '0;
    end else begin
      valid_q <= 1'b0;
      if (pend_q && req_ready_i) begin
        out_q   <= pend_req_q;
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end else if (cmd_fire_i && req_ready_i) begin
        out_q   <= cmd_i;
        valid_q <= 1'b1;
      end else if (cmd_fire_i) begin
        pend_q     <= 1'b1;
        pend_req_q <= cmd_i;
      end
    end
  end

  assign req_valid_o = valid_q;
  assign req_o       = out_q;
  assign slot_busy_o = pend_q;
endmodule

// File: rtl/ipi_cmd_decoder.sv
`timescale 1ns/1ps
module ipi_cmd_decoder
  import ipi_cmd_pkg::*;
#(
  parameter int             IDX_W      = 8,
  parameter logic [IDX_W-1:0] IDX_CMD_LO = 8'h30,
  parameter logic [IDX_W-1:0] IDX_CMD_HI = 8'h31,
  parameter logic [IDX_W-1:0] IDX_SELF   = 8'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [63:0]      wr_data_i,
  output logic             wr_err_o,
  output logic             esr_illegal_o,
  input  logic             req_ready_i,
  output logic             req_valid_o,
  output logic [1:0]       req_kind_o,
  output logic [7:0]       req_vector_o,
  output logic [2:0]       req_dlv_o,
  output logic             req_dest_mode_o,
  output logic             req_trigger_o,
  output logic [1:0]       req_shorthand_o,
  output logic [31:0]      req_dest_o
);
  logic     cmd_fire;
  ipi_req_t cmd;
  logic     wr_reject;
  logic     wr_illegal;
  logic     slot_busy;
  ipi_req_t req;
  logic     err_q;
  logic     esr_q;

  ipi_cmd_regs #(
    .IDX_W(IDX_W), .IDX_CMD_LO(IDX_CMD_LO), .IDX_CMD_HI(IDX_CMD_HI),
    .IDX_SELF(IDX_SELF)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i), .wr_en_i(wr_en_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .slot_busy_i(slot_busy),
    .cmd_fire_o(cmd_fire), .cmd_o(cmd), .wr_reject_o(wr_reject),
    .wr_illegal_o(wr_illegal)
  );

  ipi_cmd_issue issue_i (
    .clk(clk), .rst_n(rst_n), .cmd_fire_i(cmd_fire), .cmd_i(cmd),
    .req_ready_i(req_ready_i), .req_valid_o(req_valid_o), .req_o(req),
    .slot_busy_o(slot_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      esr_q <= 1'b0;
    end else begin
      err_q <= wr_reject | wr_illegal;
      esr_q <= esr_q | wr_illegal;
    end
  end

  assign wr_err_o        = err_q;
  assign esr_illegal_o   = esr_q;
  assign req_kind_o      = req.kind;
  assign req_vector_o    = req.vector;
  assign req_dlv_o       = req.dlv;
  assign req_dest_mode_o = req.dest_mode;
  assign req_trigger_o   = req.trigger;
  assign req_shorthand_o = req.shorthand;
  assign req_dest_o      = req.dest;
endmodule

// File: rtl/ipi_cmd_decoder_chk.sv
`timescale 1ns/1ps
module ipi_cmd_decoder_chk #(
  parameter int             IDX_W      = 8,
  parameter logic [IDX_W-1:0] IDX_CMD_LO = 8'h30,
  parameter logic [IDX_W-1:0] IDX_CMD_HI = 8'h31,
  parameter logic [IDX_W-1:0] IDX_SELF   = 8'h3F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode_i,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [63:0]      wr_data_i,
  input logic             req_ready_i,
  input logic             wr_err_o,
  input logic             esr_illegal_o,
  input logic             req_valid_o,
  input logic [1:0]       req_kind_o,
  input logic [7:0]       req_vector_o,
  input logic [2:0]       req_dlv_o,
  input logic             req_trigger_o,
  input logic [1:0]       req_shorthand_o,
  input logic             slot_busy
);
  logic unknown_idx;
  assign unknown_idx = (wr_idx_i != IDX_CMD_LO) && (wr_idx_i != IDX_CMD_HI) &&
                       (wr_idx_i != IDX_SELF);

  p_hi_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_idx_i == IDX_CMD_HI && ext_mode_i |=> wr_err_o);

  p_hi_no_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_idx_i == IDX_CMD_HI && !slot_busy |=> !req_valid_o);

  p_arb_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_kind_o == 2'd1 |-> req_dlv_o == 3'b101 && req_trigger_o);

  p_startup_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_kind_o == 2'd2 |-> req_dlv_o == 3'b110);

  p_self_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_idx_i == IDX_SELF && !ext_mode_i |=> wr_err_o);

  p_self_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_idx_i == IDX_SELF && ext_mode_i && !slot_busy && req_ready_i
    |=> req_valid_o && req_vector_o == $past(wr_data_i[7:0]) &&
        req_shorthand_o == 2'b01 && req_kind_o == 2'd0);

  p_illegal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && unknown_idx |=> esr_illegal_o && wr_err_o);

  p_esr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    esr_illegal_o |=> esr_illegal_o);

  p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && (wr_idx_i == IDX_CMD_LO || wr_idx_i == IDX_SELF) && slot_busy
    |=> wr_err_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_busy && !req_ready_i |=> slot_busy && !req_valid_o);

  p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> $past(req_ready_i));
endmodule

bind ipi_cmd_decoder ipi_cmd_decoder_chk #(
  .IDX_W(IDX_W), .IDX_CMD_LO(IDX_CMD_LO), .IDX_CMD_HI(IDX_CMD_HI),
  .IDX_SELF(IDX_SELF)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i), .wr_en_i(wr_en_i),
  .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .req_ready_i(req_ready_i),
  .wr_err_o(wr_err_o), .esr_illegal_o(esr_illegal_o),
  .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
  .req_vector_o(req_vector_o), .req_dlv_o(req_dlv_o),
  .req_trigger_o(req_trigger_o), .req_shorthand_o(req_shorthand_o),
  .slot_busy(slot_busy)
);

// File: tb/ipi_cmd_decoder_tb.sv
`timescale 1ns/1ps
module ipi_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        ready = 1'b1;
  logic        wr_err, esr_ill, req_valid, req_dm, req_trg;
  logic [1:0]  req_kind, req_sh;
  logic [7:0]  req_vec;
  logic [2:0]  req_dlv;
  logic [31:0] req_dest;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .wr_en_i(wr_en),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_err_o(wr_err),
    .esr_illegal_o(esr_ill), .req_ready_i(ready), .req_valid_o(req_valid),
    .req_kind_o(req_kind), .req_vector_o(req_vec), .req_dlv_o(req_dlv),
    .req_dest_mode_o(req_dm), .req_trigger_o(req_trg),
    .req_shorthand_o(req_sh), .req_dest_o(req_dest)
  );

  function automatic logic [48:0] pack(input logic [1:0] k, input logic [7:0] v,
      input logic [2:0] d, input logic m, input logic t, input logic [1:0] s,
      input logic [31:0] dst);
    return {k, v, d, m, t, s, dst};
  endfunction

  function automatic logic [48:0] obs();
    return pack(req_kind, req_vec, req_dlv, req_dm, req_trg, req_sh, req_dest);
  endfunction

  function automatic logic [1:0] exp_kind(input int d, input int l, input int t);
    if (d == 6) return 2'd2;
    if (d == 5 && l == 0 && t == 1) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive a write at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [7:0] idx, input logic [63:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [48:0] e;
    logic [48:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid, "R9 reset valid", {63'b0, req_valid}, 0);
    chk(!wr_err, "R8 reset err", {63'b0, wr_err}, 0);
    chk(!esr_ill, "R7 reset esr", {63'b0, esr_ill}, 0);

    // Compact mode: high write stores only.
    wr(8'h31, {32'hFFFF_FFFF, 8'hC3, 24'h123456});
    chk(!req_valid && !wr_err, "R2 hi write no send", {62'b0, req_valid, wr_err}, 0);

    // Sweep every field combination in compact mode.
    for (int d = 0; d < 8; d++)
      for (int l = 0; l < 2; l++)
        for (int t = 0; t < 2; t++)
          for (int s = 0; s < 4; s++)
            for (int m = 0; m < 2; m++) begin
              logic [7:0] v;
              logic [31:0] lo;
              v  = 8'((d * 37 + s * 11 + l * 5 + t * 3 + m) & 255);
              lo = {12'hABC, s[1:0], 2'b11, t[0], l[0], 2'b11, m[0], d[2:0], v};
              wr(8'h30, {32'h5555_AAAA, lo});
              e = pack(exp_kind(d, l, t), v, d[2:0], m[0], t[0], s[1:0], 32'h0000_00C3);
              chk(req_valid && obs() == e,
                  (d == 6) ? "R5 startup" : (d == 5) ? "R4 init" : "R1 decode",
                  {15'b0, obs()}, {15'b0, e});
            end

    // R9: pulse lasts one cycle, fields held.
    held = obs();
    idle();
    chk(!req_valid && obs() == held, "R9 pulse width/hold", {14'b0, req_valid, obs()},
        {15'b0, held});

    // Extended mode sweep of destinations.
    ext_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] dst;
      dst = (32'h1111_1111 * i) ^ 32'hA5C3_0F96;
      wr(8'h30, {dst, 32'h0000_0041 + 32'(i)});
      e = pack(2'd0, 8'(8'h41 + i), 3'd0, 1'b0, 1'b0, 2'd0, dst);
      chk(req_valid && obs() == e, "R3 full dest", {15'b0, obs()}, {15'b0, e});
    end

    // R3: high write refused and keeps stored high word.
    wr(8'h30, {32'hDEAD_BEEF, 32'h0000_0020});
    wr(8'h31, 64'h0000_0000_1100_0000);
    chk(wr_err && !req_valid, "R3 hi refused", {62'b0, wr_err, req_valid}, 64'h2);
    idle();
    chk(!wr_err, "R8 err one cycle", {63'b0, wr_err}, 0);
    ext_mode = 1'b0;
    wr(8'h30, 64'h0000_0000_0000_0021);
    chk(req_valid && req_dest == 32'h0000_00DE, "R8 no state change on refuse",
        {32'b0, req_dest}, 64'hDE);

    // Self-interrupt register.
    wr(8'h3F, 64'hFFFF_FFFF_FFFF_FF3C);
    chk(wr_err && !req_valid, "R6 self refused compact", {62'b0, wr_err, req_valid}, 64'h2);
    ext_mode = 1'b1;
    wr(8'h3F, 64'hFFFF_FFFF_FFFF_FF3C);
    e = pack(2'd0, 8'h3C, 3'd0, 1'b0, 1'b0, 2'b01, 32'h0);
    chk(req_valid && !wr_err && obs() == e, "R6 self send", {15'b0, obs()}, {15'b0, e});

    // Illegal index.
    wr(8'h20, 64'h1234);
    chk(wr_err && esr_ill && !req_valid, "R7 illegal index",
        {61'b0, wr_err, esr_ill, req_valid}, 64'h6);
    idle();
    chk(esr_ill && !wr_err, "R7 sticky flag", {62'b0, esr_ill, wr_err}, 64'h2);

    // Back-pressure.
    ready = 1'b0;
    wr(8'h30, {32'h0000_0077, 32'h0000_C611});
    chk(!req_valid && !wr_err, "R10 held", {62'b0, req_valid, wr_err}, 0);
    wr(8'h30, {32'h0000_0088, 32'h0000_0022});
    chk(wr_err && !req_valid, "R10 busy refused", {62'b0, wr_err, req_valid}, 64'h2);
    idle();
    chk(!req_valid, "R10 stalls while not ready", {63'b0, req_valid}, 0);
    ready = 1'b1;
    idle();
    e = pack(2'd2, 8'h11, 3'd6, 1'b0, 1'b1, 2'b00, 32'h0000_0077);
    chk(req_valid && obs() == e, "R10 issue on ready", {15'b0, obs()}, {15'b0, e});
    idle();
    chk(!req_valid, "R9 single pulse after slot", {63'b0, req_valid}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule